// File: doc/BRIEF.md
# Latched-Address Nonvolatile Memory Bus Bridge

This bridge connects an 8-bit CPU bus to a small 64-location parallel nonvolatile memory. The memory's address pins are not driven from the CPU address bus. They come from a latch that loads only when the CPU writes somewhere inside a 64-byte window, and the same write loads the data byte into a second latch that feeds the memory's data-in pins. A read therefore begins with a throwaway write to the wanted location. The only purpose of that write is to set the address.

A separate write-only control register holds four bits that drive the memory's strobe pins directly. A read of the read-register address enables the memory outputs onto the CPU data bus. Unless the hold-off bit of the control register is set, the write-data latch drives the bus at the same time. The two drivers are modelled as a wired AND, so a missing disable shows up as cleared bits.

Top module: `nvm_latch_bridge`

## Requirements
- R1: After reset, `mem_addr`, `mem_din` and `mem_ctrl` are all zero, so every control pin is inactive.
- R2: A clocked write (`cpu_wr`=1) with `cpu_addr[15:6]` equal to the window base 0x6000 loads `cpu_addr[5:0]` into `mem_addr` on that clock edge.
- R3: The same window write loads `cpu_wdata` into `mem_din`.
- R4: A write whose address lies outside the window leaves `mem_addr` and `mem_din` unchanged.
- R5: No read, at any address including window addresses and the read register, changes `mem_addr` or `mem_din`.
- R6: A write to the control address 0x6040 loads `cpu_wdata[3:0]` into `mem_ctrl[3:0]`, which drive the memory control pins directly. Data bits 7:4 are ignored, and a control write does not touch `mem_addr`.
- R7: While `cpu_rd`=1 with `cpu_addr`=0x6050, `mem_oe` and `cpu_rdata_oe` are 1 in that same cycle. In every other cycle both are 0 and `cpu_rdata` is 0x00.
- R8: During a read-register access with `mem_ctrl[3]`=0, `cpu_rdata` equals `mem_dout & mem_din`, because the write latch leaks onto the bus.
- R9: During a read-register access with `mem_ctrl[3]`=1 (hold-off), `cpu_rdata` equals `mem_dout` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| cpu_rdata_oe | output | 1 | Bridge is driving the CPU data bus |
| mem_addr | output | 6 | Latched memory address |
| mem_din | output | 8 | Latched write data to the memory |
| mem_ctrl | output | 4 | Control-register bits to the memory pins; bit 3 also withholds the write latch from the bus |
| mem_oe | output | 1 | Memory output enable |
| mem_dout | input | 8 | Memory output data |

## Verification
Two things can happen in the same cycle: the memory is driving its data out, and the write latch is leaking onto the bus. Both occur during any read-register access made while the hold-off bit is clear. The bench sets up this overlap on purpose. It stores known bytes, reloads the address with a dummy write that carries random data, and reads with the hold-off bit randomly set or cleared. The returned byte is compared with the memory content ANDed with the dummy-write data, or with the memory content alone when hold-off is set. Reads aimed at window addresses are mixed in, to confirm that the latched address survives them.

// File: rtl/nvm_latch_bridge.sv
module nvm_latch_bridge #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int MAW = 6,
  parameter int CW = 4,
  parameter int HOLD_BIT = 3,
  parameter logic [AW-1:0] WIN_BASE = 16'h6000,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h6040,
  parameter logic [AW-1:0] RDREG_ADDR = 16'h6050
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rdata_oe,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0] mem_din,
  output logic [CW-1:0] mem_ctrl,
  output logic          mem_oe,
  input  logic [DW-1:0] mem_dout
);
  logic win_wr, ctrl_wr, leak;

  assign win_wr  = cpu_wr && (cpu_addr[AW-1:MAW] == WIN_BASE[AW-1:MAW]);
  assign ctrl_wr = cpu_wr && (cpu_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_din  <= '0;
      mem_ctrl <= '0;
    end else begin
      if (win_wr) begin
        mem_addr <= cpu_addr[MAW-1:0];
        mem_din  <= cpu_wdata;
      end
      if (ctrl_wr) mem_ctrl <= cpu_wdata[CW-1:0];
    end
  end

  assign mem_oe       = cpu_rd && (cpu_addr == RDREG_ADDR);
  assign cpu_rdata_oe = mem_oe;
  assign leak         = !mem_ctrl[HOLD_BIT];
  assign cpu_rdata    = mem_oe ? (mem_dout & (leak ? mem_din : {DW{1'b1}})) : '0;
endmodule

module nvm_latch_bridge_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int MAW = 6,
  parameter int CW = 4,
  parameter int HOLD_BIT = 3,
  parameter logic [AW-1:0] WIN_BASE = 16'h6000,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h6040,
  parameter logic [AW-1:0] RDREG_ADDR = 16'h6050
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [DW-1:0] cpu_rdata,
  input logic          cpu_rdata_oe,
  input logic [MAW-1:0] mem_addr,
  input logic [DW-1:0] mem_din,
  input logic [CW-1:0] mem_ctrl,
  input logic          mem_oe,
  input logic [DW-1:0] mem_dout
);
  a_r2_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[AW-1:MAW] == WIN_BASE[AW-1:MAW]) |=> mem_addr == $past(cpu_addr[MAW-1:0]));
  a_r3_data_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[AW-1:MAW] == WIN_BASE[AW-1:MAW]) |=> mem_din == $past(cpu_wdata));
  a_r4_outside_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[AW-1:MAW] != WIN_BASE[AW-1:MAW]) |=> ($stable(mem_addr) && $stable(mem_din)));
  a_r5_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr) |=> ($stable(mem_addr) && $stable(mem_din)));
  a_r6_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == CTRL_ADDR) |=> mem_ctrl == $past(cpu_wdata[CW-1:0]));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> (!mem_oe && !cpu_rdata_oe && cpu_rdata == '0));
  a_r8_leak_and: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == RDREG_ADDR && !mem_ctrl[HOLD_BIT]) |-> cpu_rdata == (mem_dout & mem_din));
  a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == RDREG_ADDR && mem_ctrl[HOLD_BIT]) |-> cpu_rdata == mem_dout);
endmodule

bind nvm_latch_bridge nvm_latch_bridge_chk #(
  .AW(AW), .DW(DW), .MAW(MAW), .CW(CW), .HOLD_BIT(HOLD_BIT),
  .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR), .RDREG_ADDR(RDREG_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
  .mem_addr(mem_addr), .mem_din(mem_din), .mem_ctrl(mem_ctrl), .mem_oe(mem_oe),
  .mem_dout(mem_dout)
);

// File: tb/nvm_latch_bridge_tb_top.sv
module nvm_latch_bridge_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata, mem_din, mem_dout;
  logic cpu_wr = 0, cpu_rd = 0, cpu_rdata_oe, mem_oe;
  logic [5:0] mem_addr;
  logic [3:0] mem_ctrl;
  logic [7:0] arr [64];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_mem [64];
  logic [5:0] m_addr;
  logic [7:0] m_din;
  logic [3:0] m_ctrl;

  always #10 clk = ~clk;

  nvm_latch_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .mem_addr(mem_addr), .mem_din(mem_din), .mem_ctrl(mem_ctrl), .mem_oe(mem_oe),
    .mem_dout(mem_dout)
  );

  // memory model: control bit 0 is its write strobe
  always_ff @(posedge clk) if (mem_ctrl[0]) arr[mem_addr] <= mem_din;
  assign mem_dout = mem_oe ? arr[mem_addr] : 8'hFF;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read();
    return m_mem[m_addr] & (m_ctrl[3] ? 8'hFF : m_din);
  endfunction

  function automatic bit in_win(logic [15:0] a);
    return a[15:6] == 10'h180;
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
    if (in_win(a)) begin m_addr = a[5:0]; m_din = d; end
    if (a == 16'h6040) m_ctrl = d[3:0];
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1;
    #5 d = cpu_rdata; oe = cpu_rdata_oe & mem_oe;
    @(negedge clk);
    cpu_rd = 0;
  endtask

  task automatic store(logic [5:0] a, logic [7:0] d);
    wr({10'h180, a}, d);
    wr(16'h6040, {4'h0, m_ctrl[3], 3'b001});
    wr(16'h6040, {4'h0, m_ctrl[3], 3'b000});
    m_mem[a] = d;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 64; i++) begin arr[i] = 8'h00; m_mem[i] = 8'h00; end
    m_addr = '0; m_din = '0; m_ctrl = '0;
    repeat (3) @(negedge clk);
    check("R1 addr", mem_addr, 0);
    check("R1 din", mem_din, 0);
    check("R1 ctrl", mem_ctrl, 0);
    rst_n = 1;

    @(negedge clk);
    check("R7 idle oe", {cpu_rdata_oe, mem_oe}, 0);
    check("R7 idle data", cpu_rdata, 0);

    wr(16'h603F, 8'hA5);
    check("R2 top of window", mem_addr, 6'h3F);
    check("R3 data", mem_din, 8'hA5);
    wr(16'h6000, 8'h3C);
    check("R2 base of window", mem_addr, 6'h00);
    wr(16'h6040, 8'hF2);
    check("R6 upper bits ignored", mem_ctrl, 4'h2);
    check("R6 addr untouched", mem_addr, 6'h00);
    wr(16'h6040, 8'h00);
    wr(16'h5FFF, 8'h11);
    check("R4 below window", {mem_addr, mem_din}, {6'h00, 8'h3C});
    wr(16'h6041, 8'h22);
    check("R4 above window", {mem_addr, mem_din}, {6'h00, 8'h3C});

    store(6'h15, 8'hF0);
    wr(16'h6015, 8'h3C);
    rd(16'h6050, d, oe);
    check("R7 read enables", oe, 1);
    check("R8 leak AND", d, 8'h30);
    check("R5 addr after read", mem_addr, 6'h15);
    wr(16'h6040, 8'h08);
    rd(16'h6050, d, oe);
    check("R9 hold-off", d, 8'hF0);
    rd(16'h6007, d, oe);
    check("R7 read elsewhere no oe", {oe, d}, 9'h000);
    check("R5 window read keeps addr", {mem_addr, mem_din}, {6'h15, 8'h3C});

    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 4);
      logic [5:0] a = 6'($urandom);
      logic [7:0] v = 8'($urandom);
      case (op)
        0: store(a, v);
        1: begin
          wr(16'h6040, {4'h0, 1'($urandom), 3'b000});
          wr({10'h180, a}, v);
          rd(16'h6050, d, oe);
          if (m_ctrl[3]) check("R9 random read", d, exp_read());
          else check("R8 random read", d, exp_read());
          check("R7 random oe", oe, 1);
        end
        2: begin
          logic [15:0] x = 16'($urandom);
          if (in_win(x) || x == 16'h6040) x = 16'h7000 | x[11:0];
          wr(x, v);
          check("R4 random outside", {mem_addr, mem_din}, {m_addr, m_din});
        end
        3: begin
          rd({10'h180, a}, d, oe);
          check("R5 random window read", {mem_addr, mem_din}, {m_addr, m_din});
        end
        default: begin
          wr(16'h6040, {v[7:4], v[3], 3'b000});
          check("R6 random ctrl", mem_ctrl, m_ctrl);
        end
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule